// File: doc/BRIEF.md
# Prescaled Shift-Pulse Sequencer

This block paces an iterative multiply or divide datapath. A command is presented as a one-cycle start strobe, together with an operation code, an operand width given in bytes, and a prescale select. When the operation code asks for arithmetic, the sequencer produces a run of single-cycle shift enables. The run holds exactly one pulse per operand bit plus one, so it has 8N+1 pulses when the operand spans N bytes.

With the prescaler off, the shift enables come on consecutive clock cycles. With the prescaler on, they are spread out by a divisor that follows the operand width and is not set on its own. The divisor is 2 for one byte, 4 for two bytes, and 8 for three or four bytes. Each enable falls on the final clock of its prescale period.

A busy flag covers the whole run. A single-cycle done pulse follows the last shift. A synchronous clear returns the sequencer to idle at any point.

Top module: `shift_pulse_seq`

## Requirements
- R1: While clear is high and in the cycle after it, shift_en, busy and done are all 0.
- R2: With pre_en=0 at start, shift_en is high on every cycle of the run, starting in the first cycle after the start edge, and shift_en is never high while busy is low.
- R3: With pre_en=1 at start, the divisor S is 2, 4, 8 or 8 for N = 1, 2, 3 or 4. Shift enables fall only on run cycles k (counted from 1 after the start edge) where k is a multiple of S.
- R4: An accepted command yields exactly 8N+1 shift enables, where N = units_sel + 1 (units_sel 0..3 encodes 1..4 bytes): 9, 17, 25 or 33 pulses.
- R5: busy is high for exactly S*(8N+1) cycles, with S = 1 when the prescaler is off. For example, this is 264 cycles for N=4 with the prescaler on.
- R6: A start with op = 2'b00 (no operation) or op = 2'b11 (reserved) produces no shift enable, no busy and no done. Only op = 2'b01 (multiply) and op = 2'b10 (divide) run.
- R7: A start while busy is high is ignored, including on the cycle of the final shift. A start in the done cycle, when busy is already low, is accepted.
- R8: done is high for exactly one cycle, the cycle right after the last shift enable. busy is low in that cycle.
- R9: A clear during a run ends it at once: no further shift enables and no done.
- R10: A clear in the same cycle as a start wins, and the command is dropped.
- R11: op, units_sel and pre_en are captured at the accepting edge. Changing them during a run changes neither the pulse count nor the spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high clear |
| start | input | 1 | One-cycle command strobe |
| op | input | 2 | 00 none, 01 multiply, 10 divide, 11 reserved |
| units_sel | input | 2 | Operand bytes minus one |
| pre_en | input | 1 | 1 selects the width-tied prescaler |
| shift_en | output | 1 | One-cycle shift enable for the datapath |
| busy | output | 1 | High for the whole run |
| done | output | 1 | One-cycle pulse after the last shift |

## Verification
Two functions can land in the same cycle: a fresh start request, and the final shift that ends a run. Two similar cases follow from this. A clear can coincide with a start, and a start can arrive in the done cycle.

The bench raises start on the exact cycle of the last shift enable. It judges by the busy count across a window that the request was dropped. It then repeats the request one cycle later, in the done cycle, and expects a new run to begin. Clear is also raised together with start at idle. A clear is driven mid-run, and the bench checks that the pulse and done counts stop where the clear landed.

// File: rtl/shift_seq_pkg.sv
package shift_seq_pkg;

    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_MUL  = 2'b01,
        OP_DIV  = 2'b10,
        OP_RSVD = 2'b11
    } seq_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

    // number of shift steps for a given operand width in units
    function automatic int unsigned step_total(int unsigned units, int unsigned unit_bits);
        return units * unit_bits + 1;
    endfunction

    // log2 of the prescale divisor; grows with width, saturating at cap
    function automatic int unsigned prescale_log2(int unsigned units, int unsigned cap);
        return (units < cap) ? units : cap;
    endfunction

    function automatic logic op_runs(seq_op_e op);
        return (op == OP_MUL) || (op == OP_DIV);
    endfunction

endpackage

// File: rtl/seq_cmd_decode.sv
module seq_cmd_decode
    import shift_seq_pkg::*;
#(
    parameter int MAX_UNITS = 4,
    parameter int UNIT_BITS = 8,
    parameter int PRE_CAP   = 3,
    parameter int SEL_W     = 2,
    parameter int DIV_W     = 3,
    parameter int CNT_W     = 6
) (
    input  logic             start_i,
    input  logic             busy_i,
    input  seq_op_e          op_i,
    input  logic [SEL_W-1:0] units_sel_i,
    input  logic             pre_en_i,
    output logic             accept_o,
    output logic [DIV_W-1:0] last_phase_o,
    output logic [CNT_W-1:0] last_count_o
);

    int unsigned units_i;
    int unsigned lg_i;

    always_comb begin
        units_i = 32'(units_sel_i) + 32'd1;
        if (units_i > 32'(MAX_UNITS)) begin
            units_i = 32'(MAX_UNITS);
        end
        lg_i = prescale_log2(units_i, 32'(PRE_CAP));
        accept_o = start_i && !busy_i && op_runs(op_i);
        if (pre_en_i) begin
            last_phase_o = DIV_W'((32'd1 << lg_i) - 32'd1);
        end else begin
            last_phase_o = '0;
        end
        last_count_o = CNT_W'(step_total(units_i, 32'(UNIT_BITS)) - 32'd1);
    end

endmodule

// File: rtl/seq_rate_div.sv
module seq_rate_div #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic             run_i,
    input  logic [DIV_W-1:0] last_i,
    output logic             tick_o
);

    logic [DIV_W-1:0] phase_q;
    logic [DIV_W-1:0] lim_q;

    assign tick_o = run_i && (phase_q == lim_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            lim_q   <= '0;
        end else if (load_i) begin
            phase_q <= '0;
            lim_q   <= last_i;
        end else if (tick_o) begin
            phase_q <= '0;
        end else if (run_i) begin
            phase_q <= phase_q + 1'b1;
        end
    end

endmodule

// File: rtl/seq_pulse_ctr.sv
module seq_pulse_ctr #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] last_i,
    output logic             final_o
);

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] lim_q;

    assign final_o = tick_i && (count_q == lim_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            lim_q   <= '0;
        end else if (load_i) begin
            count_q <= '0;
            lim_q   <= last_i;
        end else if (tick_i) begin
            count_q <= count_q + 1'b1;
        end
    end

endmodule

// File: rtl/shift_pulse_seq.sv
module shift_pulse_seq
    import shift_seq_pkg::*;
#(
    parameter int MAX_UNITS = 4,
    parameter int UNIT_BITS = 8,
    parameter int PRE_CAP   = 3,
    localparam int SEL_W    = (MAX_UNITS > 1) ? $clog2(MAX_UNITS) : 1,
    localparam int DIV_W    = (PRE_CAP > 0) ? PRE_CAP : 1,
    localparam int CNT_W    = $clog2(MAX_UNITS * UNIT_BITS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [1:0]       op,
    input  logic [SEL_W-1:0] units_sel,
    input  logic             pre_en,
    output logic             shift_en,
    output logic             busy,
    output logic             done
);

    seq_state_e       state_q;
    logic             done_q;
    logic             accept;
    logic             tick;
    logic             last_tick;
    logic [DIV_W-1:0] last_phase;
    logic [CNT_W-1:0] last_count;

    assign busy     = (state_q == ST_RUN);
    assign shift_en = tick;
    assign done     = done_q;

    seq_cmd_decode #(
        .MAX_UNITS (MAX_UNITS),
        .UNIT_BITS (UNIT_BITS),
        .PRE_CAP   (PRE_CAP),
        .SEL_W     (SEL_W),
        .DIV_W     (DIV_W),
        .CNT_W     (CNT_W)
    ) u_decode (
        .start_i      (start),
        .busy_i       (busy),
        .op_i         (seq_op_e'(op)),
        .units_sel_i  (units_sel),
        .pre_en_i     (pre_en),
        .accept_o     (accept),
        .last_phase_o (last_phase),
        .last_count_o (last_count)
    );

    seq_rate_div #(
        .DIV_W (DIV_W)
    ) u_rate (
        .clk    (clk),
        .rst    (rst),
        .load_i (accept),
        .run_i  (busy),
        .last_i (last_phase),
        .tick_o (tick)
    );

    seq_pulse_ctr #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk     (clk),
        .rst     (rst),
        .load_i  (accept),
        .tick_i  (tick),
        .last_i  (last_count),
        .final_o (last_tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            done_q <= last_tick;
            if (accept) begin
                state_q <= ST_RUN;
            end else if (last_tick) begin
                state_q <= ST_IDLE;
            end
        end
    end

endmodule

// File: rtl/shift_pulse_seq_chk.sv
module shift_pulse_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic [1:0] op,
    input logic       shift_en,
    input logic       busy,
    input logic       done
);

    logic started = 1'b0;

    always_ff @(posedge clk) begin
        started <= 1'b1;
    end

    AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (rst)
        (started && $past(rst)) |-> (!busy && !done && !shift_en)); // R1

    AST_SHIFT_IN_RUN: assert property (@(posedge clk) disable iff (rst)
        shift_en |-> busy); // R2

    AST_RUN_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && (op == 2'b01 || op == 2'b10)) |=> busy); // R4

    AST_NOOP_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && (op == 2'b00 || op == 2'b11)) |=> !busy); // R6

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !shift_en) |=> busy); // R7

    AST_DONE_AFTER_SHIFT: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(shift_en) && !busy)); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8

    AST_END_GIVES_DONE: assert property (@(posedge clk) disable iff (rst)
        (started && !$past(rst) && $fell(busy)) |-> done); // R8

endmodule

bind shift_pulse_seq shift_pulse_seq_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .op       (op),
    .shift_en (shift_en),
    .busy     (busy),
    .done     (done)
);

// File: tb/shift_pulse_seq_bench.sv
`timescale 1ns/1ps
module shift_pulse_seq_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [1:0] op = 2'b00;
    logic [1:0] units_sel = 2'b00;
    logic       pre_en = 1'b0;
    logic       shift_en;
    logic       busy;
    logic       done;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    shift_pulse_seq u_shift_pulse_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .op        (op),
        .units_sel (units_sel),
        .pre_en    (pre_en),
        .shift_en  (shift_en),
        .busy      (busy),
        .done      (done)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle_clear();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic launch(input logic [1:0] o, input int n, input logic p);
        op = o;
        units_sel = 2'(n - 1);
        pre_en = p;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // samples run cycles 1..limit; may poke the block at cycle poke_at
    task automatic measure(input int s, input int limit, input int poke_at, input int kind,
                           output int busy_n, output int pulses, output int done_n,
                           output int first_done, output int spacing_bad);
        busy_n = 0; pulses = 0; done_n = 0; first_done = -1; spacing_bad = 0;
        for (int k = 1; k <= limit; k++) begin
            if (busy) busy_n++;
            if (shift_en) begin
                pulses++;
                if ((k % s) != 0) spacing_bad++;
            end
            if (done) begin
                done_n++;
                if (first_done < 0) first_done = k;
            end
            if (k == poke_at) begin
                case (kind)
                    1: begin start = 1'b1; op = 2'b10; units_sel = 2'd3; pre_en = 1'b1; end
                    2: rst = 1'b1;
                    3: begin units_sel = 2'd3; pre_en = 1'b1; op = 2'b00; end
                    default: ;
                endcase
            end
            if (k == poke_at + 1) begin
                start = 1'b0;
                rst = 1'b0;
            end
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 busy in clear", int'(busy), 0);
        chk("R1 shift_en in clear", int'(shift_en), 0);
        chk("R1 done in clear", int'(done), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 busy after clear", int'(busy), 0);
    endtask

    task automatic t_run(input int n, input logic p);
        int s, t, b, pu, dn, fd, sb;
        s = !p ? 1 : (n == 1) ? 2 : (n == 2) ? 4 : 8;
        t = s * (8 * n + 1);
        idle_clear();
        launch(2'b01, n, p);
        measure(s, t + 3, 0, 0, b, pu, dn, fd, sb);
        chk("R4 pulse count", pu, 8 * n + 1);
        chk("R5 busy length", b, t);
        chk("R8 done cycle", fd, t + 1);
        chk("R8 done width", dn, 1);
        chk(p ? "R3 prescaled spacing" : "R2 every-cycle spacing", sb, 0);
    endtask

    task automatic t_noop(input logic [1:0] o);
        int b, pu, dn, fd, sb;
        idle_clear();
        launch(o, 2, 1'b0);
        measure(1, 40, 0, 0, b, pu, dn, fd, sb);
        chk("R6 no busy on idle op", b, 0);
        chk("R6 no shift on idle op", pu, 0);
        chk("R6 no done on idle op", dn, 0);
    endtask

    task automatic t_start_while_busy();
        int b, pu, dn, fd, sb;
        idle_clear();
        launch(2'b01, 2, 1'b0);
        measure(1, 22, 5, 1, b, pu, dn, fd, sb);
        chk("R7 mid-run start pulses", pu, 17);
        chk("R7 mid-run start busy", b, 17);
        chk("R7 mid-run start done", fd, 18);
    endtask

    task automatic t_start_last_shift();
        int b, pu, dn, fd, sb;
        idle_clear();
        launch(2'b10, 1, 1'b0);
        measure(1, 14, 9, 1, b, pu, dn, fd, sb);
        chk("R7 start on last shift busy", b, 9);
        chk("R7 start on last shift done", fd, 10);
        chk("R7 start on last shift pulses", pu, 9);
    endtask

    task automatic t_start_done_cycle();
        int b, pu, dn, fd, sb;
        idle_clear();
        launch(2'b10, 1, 1'b0);
        measure(1, 14, 10, 1, b, pu, dn, fd, sb);
        chk("R7 start in done cycle accepted", b, 13);
        chk("R8 done single before rerun", dn, 1);
    endtask

    task automatic t_cfg_change();
        int b, pu, dn, fd, sb;
        idle_clear();
        launch(2'b01, 1, 1'b0);
        measure(1, 14, 3, 3, b, pu, dn, fd, sb);
        chk("R11 pulses after cfg change", pu, 9);
        chk("R11 busy after cfg change", b, 9);
        chk("R11 spacing after cfg change", sb, 0);
    endtask

    task automatic t_clear_mid();
        int b, pu, dn, fd, sb;
        idle_clear();
        launch(2'b01, 3, 1'b0);
        measure(1, 40, 6, 2, b, pu, dn, fd, sb);
        chk("R9 pulses stop at clear", pu, 6);
        chk("R9 busy stops at clear", b, 6);
        chk("R9 no done after clear", dn, 0);
    endtask

    task automatic t_clear_with_start();
        int b, pu, dn, fd, sb;
        idle_clear();
        op = 2'b01; units_sel = 2'd0; pre_en = 1'b0;
        rst = 1'b1; start = 1'b1;
        @(negedge clk);
        rst = 1'b0; start = 1'b0;
        measure(1, 20, 0, 0, b, pu, dn, fd, sb);
        chk("R10 clear beats start busy", b, 0);
        chk("R10 clear beats start pulses", pu, 0);
    endtask

    initial begin
        t_reset();
        for (int n = 1; n <= 4; n++) t_run(n, 1'b0);
        for (int n = 1; n <= 4; n++) t_run(n, 1'b1);
        t_noop(2'b00);
        t_noop(2'b11);
        t_start_while_busy();
        t_start_last_shift();
        t_start_done_cycle();
        t_cfg_change();
        t_clear_mid();
        t_clear_with_start();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule